// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit turns one decoded load/store request into the addresses a memory stage needs. It takes a base register value, a signed immediate, an indexing mode and an access-class code. From these it produces the first access address and, for two-word transfers, a second address one word above the first. It also produces the updated base value and a flag saying whether the base register should be written back. Three indexing modes are supported. Plain offset uses base plus immediate and leaves the base alone. Pre-indexed uses base plus immediate and updates the base to that sum. Post-indexed uses the unmodified base and updates the base to the sum.

The unit also checks that the immediate is legal for the encoding family and access class, including the step the immediate must be a multiple of. It checks the register-number rules: the base must not overlap a transferred register when the base is written back, and there are pairing rules for two-word transfers in the fixed-width family. An illegal request still produces addresses, but it raises an error output and never requests a writeback. Results are registered: a request presented with `in_valid` high appears on the outputs with `out_valid` high on the following clock edge.

Top module: `ls_agu`

## Requirements
- R1: With `mode_i` = 0 (plain offset), `addr0_o` equals base plus the sign-extended offset and `wb_en_o` is 0.
- R2: With `mode_i` = 1 (pre-indexed) and a legal request, `addr0_o` and `wb_data_o` both equal base plus offset and `wb_en_o` is 1.
- R3: With `mode_i` = 2 (post-indexed) and a legal request, `addr0_o` equals the unmodified base, `wb_data_o` equals base plus offset and `wb_en_o` is 1.
- R4: When `has_ofs_i` is 0 the offset input is ignored and treated as zero, so the address and writeback value equal the base.
- R5: Family 0 (32-bit fixed width): classes word (0) and unsigned byte (1) accept -4095..4095; signed byte (2), unsigned half (3), signed half (4) and doubleword (5) accept -255..255. No step rule applies. Violations raise `range_err_o`.
- R6: Family 1 (32-bit compact): classes 0..4 accept -255..4095 in plain mode and -255..255 in the indexed modes; doubleword accepts -1020..1020 and must be a multiple of 4. Violations raise `range_err_o`.
- R7: Family 2 (16-bit compact) allows plain mode only. Word allows 0..124 in steps of 4, or 0..1020 in steps of 4 when `rn_i` = 13 (stack pointer). Unsigned half allows 0..62 in steps of 2. Unsigned byte allows 0..31. Any other class, or an indexed mode, raises `range_err_o`.
- R8: In pre- or post-indexed mode, `rn_i` equal to `rt_i`, or to `rt2_i` for a doubleword, raises `reg_err_o`. Plain mode never raises this for overlap.
- R9: A family-0 doubleword raises `reg_err_o` when `rt_i` is odd, when `rt_i` is 14 (link register), or when `rt2_i` is not `rt_i`+1.
- R10: Whenever `out_valid_o` is 1, `addr1_o` equals `addr0_o` + 4.
- R11: Mode 3 and family 3 are reserved and raise `range_err_o`. Class codes 6 and 7 are reserved in every family and also raise `range_err_o`. While either error output is 1, `wb_en_o` is 0.
- R12: All outputs are 0 after reset. Each request taken with `in_valid` = 1 appears one clock edge later with `out_valid_o` = 1. Without a request, `out_valid_o`, `wb_en_o` and both error outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| base_i | input | 32 | Base register value |
| ofs_i | input | 13 | Signed immediate offset (two's complement) |
| has_ofs_i | input | 1 | Offset present; 0 forces a zero offset |
| mode_i | input | 2 | Indexing mode: 0 plain, 1 pre, 2 post, 3 reserved |
| fam_i | input | 2 | Encoding family: 0 fixed 32-bit, 1 compact 32-bit, 2 compact 16-bit, 3 reserved |
| cls_i | input | 3 | Access class: 0 word, 1 ubyte, 2 sbyte, 3 uhalf, 4 shalf, 5 doubleword, 6-7 reserved |
| rn_i | input | 4 | Base register number |
| rt_i | input | 4 | First transfer register number |
| rt2_i | input | 4 | Second transfer register number (doubleword) |
| out_valid | output | 1 | Registered result valid |
| addr0_o | output | 32 | First access address |
| addr1_o | output | 32 | Second access address (first + 4) |
| wb_data_o | output | 32 | Base writeback value |
| wb_en_o | output | 1 | Base writeback requested |
| range_err_o | output | 1 | Offset, mode, family or class illegal |
| reg_err_o | output | 1 | Register-number rule violated |

## Verification
Every result of this unit, meaning both addresses, the writeback value and enable, and both error flags, is due exactly one rising edge after the request cycle. Nothing arrives later, because the only storage is the output register. The bench drives each request on a falling edge and holds it through one rising edge. It drops `in_valid` and reads all outputs at the following falling edge, when the registered values are settled and no new edge has passed. The idle behaviour of the valid and enable outputs is read one cycle after that, with no request pending.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;

    typedef enum logic [1:0] {
        IDX_PLAIN = 2'd0,
        IDX_PRE   = 2'd1,
        IDX_POST  = 2'd2,
        IDX_RSV   = 2'd3
    } idx_mode_e;

    typedef enum logic [1:0] {
        FAM_FIXED  = 2'd0,
        FAM_WIDE   = 2'd1,
        FAM_NARROW = 2'd2,
        FAM_RSV    = 2'd3
    } fam_e;

    typedef enum logic [2:0] {
        CLS_WORD  = 3'd0,
        CLS_UBYTE = 3'd1,
        CLS_SBYTE = 3'd2,
        CLS_UHALF = 3'd3,
        CLS_SHALF = 3'd4,
        CLS_DWORD = 3'd5,
        CLS_RSV6  = 3'd6,
        CLS_RSV7  = 3'd7
    } cls_e;

    localparam int SP_IDX  = 13;
    localparam int LR_IDX  = 14;
    localparam int DW_STEP = 4;

endpackage

// File: rtl/ls_agu_range_chk.sv
module ls_agu_range_chk
    import ls_agu_pkg::*;
#(
    parameter int OFS_W = 13,
    parameter int RW    = 4
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic [1:0]       mode,
    input  logic [1:0]       fam,
    input  logic [2:0]       cls,
    input  logic [RW-1:0]    rn,
    output logic             bad
);
    localparam int WIDE_LIM  = 4095;
    localparam int SHORT_LIM = 255;
    localparam int DW_LIM    = 1020;

    idx_mode_e   mode_e;
    fam_e        fam_e_v;
    cls_e        cls_v;
    int          ofs_val;
    int          lo;
    int          hi;
    logic [1:0]  step_mask;
    logic        cls_ok;
    logic        mode_ok;
    logic        sp_base;

    always_comb begin
        mode_e    = idx_mode_e'(mode);
        fam_e_v   = fam_e'(fam);
        cls_v     = cls_e'(cls);
        ofs_val   = int'($signed(ofs));
        sp_base   = (int'(rn) == SP_IDX);
        lo        = 0;
        hi        = 0;
        step_mask = 2'b00;
        cls_ok    = (cls_v != CLS_RSV6) && (cls_v != CLS_RSV7);
        mode_ok   = (mode_e != IDX_RSV);

        unique case (fam_e_v)
            FAM_FIXED: begin
                if (cls_v == CLS_WORD || cls_v == CLS_UBYTE) begin
                    lo = -WIDE_LIM;
                    hi = WIDE_LIM;
                end else begin
                    lo = -SHORT_LIM;
                    hi = SHORT_LIM;
                end
            end
            FAM_WIDE: begin
                if (cls_v == CLS_DWORD) begin
                    lo        = -DW_LIM;
                    hi        = DW_LIM;
                    step_mask = 2'b11;
                end else begin
                    lo = -SHORT_LIM;
                    hi = (mode_e == IDX_PLAIN) ? WIDE_LIM : SHORT_LIM;
                end
            end
            FAM_NARROW: begin
                mode_ok = (mode_e == IDX_PLAIN);
                unique case (cls_v)
                    CLS_WORD: begin
                        hi        = sp_base ? 1020 : 124;
                        step_mask = 2'b11;
                    end
                    CLS_UHALF: begin
                        hi        = 62;
                        step_mask = 2'b01;
                    end
                    CLS_UBYTE: hi = 31;
                    default:   cls_ok = 1'b0;
                endcase
            end
            default: cls_ok = 1'b0;
        endcase

        bad = !cls_ok || !mode_ok || (ofs_val < lo) || (ofs_val > hi)
              || ((ofs[1:0] & step_mask) != 2'b00);
    end

endmodule

// File: rtl/ls_agu_reg_chk.sv
module ls_agu_reg_chk
    import ls_agu_pkg::*;
#(
    parameter int RW = 4
) (
    input  logic [1:0]    mode,
    input  logic [1:0]    fam,
    input  logic [2:0]    cls,
    input  logic [RW-1:0] rn,
    input  logic [RW-1:0] rt,
    input  logic [RW-1:0] rt2,
    output logic          bad
);
    localparam logic [RW-1:0] LR = RW'(LR_IDX);

    logic indexed;
    logic dword;
    logic overlap;
    logic pair_bad;

    always_comb begin
        indexed  = (idx_mode_e'(mode) == IDX_PRE) || (idx_mode_e'(mode) == IDX_POST);
        dword    = (cls_e'(cls) == CLS_DWORD);
        overlap  = indexed && ((rn == rt) || (dword && (rn == rt2)));
        pair_bad = (fam_e'(fam) == FAM_FIXED) && dword
                   && (rt[0] || (rt == LR) || (rt2 != rt + RW'(1)));
        bad      = overlap || pair_bad;
    end

endmodule

// File: rtl/ls_agu_addr_calc.sv
module ls_agu_addr_calc
    import ls_agu_pkg::*;
#(
    parameter int AW    = 32,
    parameter int OFS_W = 13
) (
    input  logic [AW-1:0]    base,
    input  logic [OFS_W-1:0] ofs,
    input  logic [1:0]       mode,
    output logic [AW-1:0]    addr0,
    output logic [AW-1:0]    addr1,
    output logic [AW-1:0]    sum,
    output logic             wants_wb
);
    localparam int EXT_W = AW - OFS_W;

    logic [AW-1:0] ofs_ext;

    always_comb begin
        ofs_ext  = {{EXT_W{ofs[OFS_W-1]}}, ofs};
        sum      = base + ofs_ext;
        unique case (idx_mode_e'(mode))
            IDX_POST: addr0 = base;
            default:  addr0 = sum;
        endcase
        addr1    = addr0 + AW'(DW_STEP);
        wants_wb = (idx_mode_e'(mode) == IDX_PRE) || (idx_mode_e'(mode) == IDX_POST);
    end

endmodule

// File: rtl/ls_agu.sv
module ls_agu
    import ls_agu_pkg::*;
#(
    parameter int AW    = 32,
    parameter int OFS_W = 13,
    parameter int RW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [AW-1:0]    base_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic             has_ofs_i,
    input  logic [1:0]       mode_i,
    input  logic [1:0]       fam_i,
    input  logic [2:0]       cls_i,
    input  logic [RW-1:0]    rn_i,
    input  logic [RW-1:0]    rt_i,
    input  logic [RW-1:0]    rt2_i,
    output logic             out_valid,
    output logic [AW-1:0]    addr0_o,
    output logic [AW-1:0]    addr1_o,
    output logic [AW-1:0]    wb_data_o,
    output logic             wb_en_o,
    output logic             range_err_o,
    output logic             reg_err_o
);
    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr0;
        logic [AW-1:0] addr1;
        logic [AW-1:0] wb_data;
        logic          wb_en;
        logic          range_err;
        logic          reg_err;
    } res_t;

    logic [OFS_W-1:0] ofs_eff;
    logic [AW-1:0]    c_addr0;
    logic [AW-1:0]    c_addr1;
    logic [AW-1:0]    c_sum;
    logic             c_wants_wb;
    logic             c_range_bad;
    logic             c_reg_bad;
    res_t             res_d;
    res_t             res_q;

    assign ofs_eff = has_ofs_i ? ofs_i : '0;

    ls_agu_addr_calc #(.AW(AW), .OFS_W(OFS_W)) addr_i (
        .base     (base_i),
        .ofs      (ofs_eff),
        .mode     (mode_i),
        .addr0    (c_addr0),
        .addr1    (c_addr1),
        .sum      (c_sum),
        .wants_wb (c_wants_wb)
    );

    ls_agu_range_chk #(.OFS_W(OFS_W), .RW(RW)) range_i (
        .ofs  (ofs_eff),
        .mode (mode_i),
        .fam  (fam_i),
        .cls  (cls_i),
        .rn   (rn_i),
        .bad  (c_range_bad)
    );

    ls_agu_reg_chk #(.RW(RW)) regs_i (
        .mode (mode_i),
        .fam  (fam_i),
        .cls  (cls_i),
        .rn   (rn_i),
        .rt   (rt_i),
        .rt2  (rt2_i),
        .bad  (c_reg_bad)
    );

    always_comb begin
        res_d           = res_q;
        res_d.valid     = in_valid;
        res_d.wb_en     = 1'b0;
        res_d.range_err = 1'b0;
        res_d.reg_err   = 1'b0;
        if (in_valid) begin
            res_d.addr0     = c_addr0;
            res_d.addr1     = c_addr1;
            res_d.wb_data   = c_sum;
            res_d.range_err = c_range_bad;
            res_d.reg_err   = c_reg_bad;
            res_d.wb_en     = c_wants_wb && !c_range_bad && !c_reg_bad;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid   = res_q.valid;
    assign addr0_o     = res_q.addr0;
    assign addr1_o     = res_q.addr1;
    assign wb_data_o   = res_q.wb_data;
    assign wb_en_o     = res_q.wb_en;
    assign range_err_o = res_q.range_err;
    assign reg_err_o   = res_q.reg_err;

    assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wb_en_o && !range_err_o && !reg_err_o));

    assert_plain_nowb_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_i == 2'd0) |=> !wb_en_o);

    assert_pre_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_i == 2'd1) |=> (addr0_o == wb_data_o));

    assert_post_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_i == 2'd2) |=> (addr0_o == $past(base_i)));

    assert_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode_i == 2'd1 || mode_i == 2'd2) && rn_i == rt_i) |=> reg_err_o);

    assert_pair_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (addr1_o == addr0_o + AW'(DW_STEP)));

    assert_err_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (range_err_o || reg_err_o) |-> !wb_en_o);

endmodule

// File: tb/ls_agu_tb_top.sv
module ls_agu_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] base_i = '0;
    logic [12:0] ofs_i = '0;
    logic        has_ofs_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [1:0]  fam_i = '0;
    logic [2:0]  cls_i = '0;
    logic [3:0]  rn_i = '0;
    logic [3:0]  rt_i = '0;
    logic [3:0]  rt2_i = '0;
    logic        out_valid;
    logic [31:0] addr0_o;
    logic [31:0] addr1_o;
    logic [31:0] wb_data_o;
    logic        wb_en_o;
    logic        range_err_o;
    logic        reg_err_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ls_agu dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_i(base_i),
        .ofs_i(ofs_i), .has_ofs_i(has_ofs_i), .mode_i(mode_i), .fam_i(fam_i),
        .cls_i(cls_i), .rn_i(rn_i), .rt_i(rt_i), .rt2_i(rt2_i),
        .out_valid(out_valid), .addr0_o(addr0_o), .addr1_o(addr1_o),
        .wb_data_o(wb_data_o), .wb_en_o(wb_en_o), .range_err_o(range_err_o),
        .reg_err_o(reg_err_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one request at a falling edge, register it, read at the next falling edge.
    task automatic issue(input int fam, input int cls, input int mode, input bit hasof,
                         input logic [31:0] b, input int o,
                         input int rn, input int rt, input int rt2);
        @(negedge clk);
        fam_i = 2'(fam); cls_i = 3'(cls); mode_i = 2'(mode); has_ofs_i = hasof;
        base_i = b; ofs_i = 13'(o); rn_i = 4'(rn); rt_i = 4'(rt); rt2_i = 4'(rt2);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_err(input string req, input int fam, input int cls,
                              input int mode, input int o, input int rn,
                              input bit exp_rng, input bit exp_reg);
        issue(fam, cls, mode, 1'b1, 32'h0000_8000, o, rn, 2, 3);
        chk(req, "range_err", 32'(range_err_o), 32'(exp_rng));
        chk(req, "reg_err", 32'(reg_err_o), 32'(exp_reg));
        if (exp_rng || exp_reg) chk(req, "wb_en gated R11", 32'(wb_en_o), 32'd0);
    endtask

    task automatic t_reset;
        chk("R12", "reset out_valid", 32'(out_valid), 32'd0);
        chk("R12", "reset addr0", addr0_o, 32'd0);
        chk("R12", "reset wb_en", 32'(wb_en_o), 32'd0);
    endtask

    task automatic t_plain;
        issue(0, 0, 0, 1'b1, 32'h0000_1000, -16, 1, 2, 3);
        chk("R12", "valid", 32'(out_valid), 32'd1);
        chk("R1", "addr0", addr0_o, 32'h0000_1000 - 32'd16);
        chk("R1", "wb_en", 32'(wb_en_o), 32'd0);
        chk("R10", "addr1", addr1_o, 32'h0000_1000 - 32'd12);
        @(negedge clk);
        chk("R12", "idle valid", 32'(out_valid), 32'd0);
    endtask

    task automatic t_pre;
        issue(0, 0, 1, 1'b1, 32'h0000_2000, 960, 5, 2, 3);
        chk("R2", "addr0", addr0_o, 32'h0000_23C0);
        chk("R2", "wb_data", wb_data_o, 32'h0000_23C0);
        chk("R2", "wb_en", 32'(wb_en_o), 32'd1);
        @(negedge clk);
        chk("R12", "idle wb_en", 32'(wb_en_o), 32'd0);
    endtask

    task automatic t_post;
        issue(1, 3, 2, 1'b1, 32'h0000_3000, -4, 6, 2, 3);
        chk("R3", "addr0", addr0_o, 32'h0000_3000);
        chk("R3", "wb_data", wb_data_o, 32'h0000_2FFC);
        chk("R3", "wb_en", 32'(wb_en_o), 32'd1);
    endtask

    task automatic t_no_offset;
        issue(0, 0, 1, 1'b0, 32'h0000_4444, 100, 7, 2, 3);
        chk("R4", "addr0", addr0_o, 32'h0000_4444);
        chk("R4", "wb_data", wb_data_o, 32'h0000_4444);
        issue(2, 0, 0, 1'b0, 32'h0000_5000, 3, 1, 2, 3);
        chk("R4", "ignored misaligned", 32'(range_err_o), 32'd0);
    endtask

    task automatic t_fixed;
        expect_err("R5", 0, 0, 0, 4095, 1, 0, 0);
        expect_err("R5", 0, 1, 1, -4095, 1, 0, 0);
        expect_err("R5", 0, 0, 2, 4096, 1, 1, 0);
        expect_err("R5", 0, 3, 0, 256, 1, 1, 0);
        expect_err("R5", 0, 4, 1, -255, 1, 0, 0);
        expect_err("R5", 0, 2, 0, -256, 1, 1, 0);
    endtask

    task automatic t_wide;
        expect_err("R6", 1, 0, 0, 4095, 1, 0, 0);
        expect_err("R6", 1, 0, 1, 256, 1, 1, 0);
        expect_err("R6", 1, 2, 0, -256, 1, 1, 0);
        expect_err("R6", 1, 5, 0, 1020, 1, 0, 0);
        expect_err("R6", 1, 5, 0, 1018, 1, 1, 0);
        expect_err("R6", 1, 5, 2, -1024, 1, 1, 0);
    endtask

    task automatic t_narrow;
        expect_err("R7", 2, 0, 0, 124, 1, 0, 0);
        expect_err("R7", 2, 0, 0, 128, 1, 1, 0);
        expect_err("R7", 2, 0, 0, 6, 1, 1, 0);
        expect_err("R7", 2, 0, 0, 1020, 13, 0, 0);
        expect_err("R7", 2, 3, 0, 62, 1, 0, 0);
        expect_err("R7", 2, 3, 0, 63, 1, 1, 0);
        expect_err("R7", 2, 1, 0, 31, 1, 0, 0);
        expect_err("R7", 2, 1, 0, 32, 1, 1, 0);
        expect_err("R7", 2, 1, 1, 4, 1, 1, 0);
        expect_err("R7", 2, 2, 0, 4, 1, 1, 0);
    endtask

    task automatic t_overlap;
        expect_err("R8", 0, 0, 1, 8, 2, 0, 1);
        expect_err("R8", 0, 0, 2, 8, 2, 0, 1);
        expect_err("R8", 0, 0, 0, 8, 2, 0, 0);
        issue(1, 5, 1, 1'b1, 32'h0000_9000, 8, 3, 2, 3);
        chk("R8", "dword rt2 overlap", 32'(reg_err_o), 32'd1);
    endtask

    task automatic t_pair;
        issue(0, 5, 0, 1'b1, 32'h0000_A000, 16, 1, 4, 5);
        chk("R9", "good pair err", 32'(reg_err_o), 32'd0);
        chk("R10", "addr1", addr1_o, 32'h0000_A014);
        issue(0, 5, 0, 1'b1, 32'h0000_A000, 16, 1, 3, 4);
        chk("R9", "odd first", 32'(reg_err_o), 32'd1);
        issue(0, 5, 0, 1'b1, 32'h0000_A000, 16, 1, 14, 15);
        chk("R9", "link reg", 32'(reg_err_o), 32'd1);
        issue(0, 5, 0, 1'b1, 32'h0000_A000, 16, 1, 4, 6);
        chk("R9", "not consecutive", 32'(reg_err_o), 32'd1);
        issue(1, 5, 0, 1'b1, 32'h0000_A000, 16, 1, 3, 7);
        chk("R9", "compact no pair rule", 32'(reg_err_o), 32'd0);
    endtask

    task automatic t_reserved;
        expect_err("R11", 0, 0, 3, 4, 1, 1, 0);
        expect_err("R11", 3, 0, 0, 4, 1, 1, 0);
        expect_err("R11", 0, 6, 0, 4, 1, 1, 0);
        expect_err("R11", 1, 5, 1, 2, 1, 1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_plain();
        t_pre();
        t_post();
        t_no_offset();
        t_fixed();
        t_wide();
        t_narrow();
        t_overlap();
        t_pair();
        t_reserved();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule